// File: doc/BRIEF.md
# Master/Slave Correlator Phase Sequencer

This block produces the slot sequencing for a multi-channel correlator device that runs either as the timing master or as a slave of another such device. Each period of the fast reference clock is one "slot". Seven slots form one sequencing cycle, and exactly one of seven one-hot phase outputs marks the current slot. The design is enable-based: it runs on one system clock, and the reference timing arrives as strobes or sampled levels.

In master mode, each reference strobe (`ref_tick`) advances a divide-by-7 counter. The same strobe toggles a half-rate clock output that drives slave devices. The block also derives a sampling clock at one seventh of the reference rate, and a slow interrupt clock for the processor.

In slave mode, only the half-rate clock from the master arrives (`slv_clk_in`). Two dividers, one advanced on rising edges and one on falling edges, each step two slots per edge. Because the two dividers interleave, the result is the same consecutive slot sequence that the master produces at full rate.

Top module: `corr_clkgen`

## Requirements
- R1: After reset, `phase_oh`, `samp_clk`, `slv_clk_out` and `irq_clk` are all 0.
- R2: In master mode (`mode_slave`=0), the k-th `ref_tick` (k from 0) makes `phase_oh` equal to one-hot bit (k mod 7). Outputs change on the clock edge that samples the tick.
- R3: In master mode, `slv_clk_out` toggles on each `ref_tick`. It goes to 1 on the first tick after reset, so it rises together with slot 0.
- R4: `samp_clk` is 1 while the active slot is 0 to 3 and 0 while it is 4 to 6, so it is high for 4 slots and low for 3 slots of every cycle.
- R5: In slave mode, each edge of `slv_clk_in` advances one slot. The first rising edge after reset gives slot 0, and alternating rising and falling edges give consecutive slots 0,1,...,6,0. Outputs change two clock edges after the level change is driven.
- R6: In slave mode, `ref_tick` has no effect and `slv_clk_out` stays 0.
- R7: In master mode, changes on `slv_clk_in` have no effect.
- R8: `irq_clk` toggles after every IRQ_HALF slot advances, where IRQ_HALF defaults to 200. This gives one interrupt-clock period per 400 slots.
- R9: At most one bit of `phase_oh` is 1 at any time, and none is 1 before the first slot advance after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_slave | input | 1 | 0 selects master mode, 1 selects slave mode (static between resets) |
| ref_tick | input | 1 | One-cycle strobe per reference-clock period (master) |
| slv_clk_in | input | 1 | Level of the half-rate clock received from a master (slave) |
| phase_oh | output | NSLOT | One-hot active slot |
| samp_clk | output | 1 | Sampling clock, one seventh of the slot rate |
| slv_clk_out | output | 1 | Half-rate clock for slave devices |
| irq_clk | output | 1 | Slow processor interrupt clock |

## Verification
A master strobe is visible at the outputs on the same edge that samples it. The bench therefore raises `ref_tick` after a falling edge, drops it at the next falling edge, and reads the outputs there. A slave level change passes through an input register before the edge detector acts, so it appears one edge later. The bench waits two falling edges after each toggle before it compares. Ignored inputs are applied in a window of their own, and the bench reads the outputs before issuing the next valid advance.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int NSLOT_DEF = 7;

  function automatic logic [NSLOT_DEF-1:0] slot_onehot(input logic [$clog2(NSLOT_DEF)-1:0] s);
    logic [NSLOT_DEF-1:0] v;
    v = '0;
    for (int i = 0; i < NSLOT_DEF; i++)
      if (s == i[$clog2(NSLOT_DEF)-1:0]) v[i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/cg_master_div.sv
module cg_master_div #(
  parameter int NSLOT = 7,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  output logic          adv,
  output logic [SW-1:0] slot,
  output logic          half_clk
);
  logic [SW-1:0] cnt;

  assign adv  = en & tick;
  assign slot = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      half_clk <= 1'b0;
    end else if (!en) begin
      half_clk <= 1'b0;
    end else if (tick) begin
      cnt      <= (cnt == SW'(NSLOT-1)) ? '0 : cnt + 1'b1;
      half_clk <= ~half_clk;
    end
  end
endmodule

// File: rtl/cg_slave_div.sv
module cg_slave_div #(
  parameter int NSLOT = 7,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          lvl_in,
  output logic          adv,
  output logic [SW-1:0] slot
);
  logic          s_cur, s_prev;
  logic [1:0]    edge_hit;
  logic [SW-1:0] div_q [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cur  <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_cur  <= lvl_in;
      s_prev <= s_cur;
    end
  end

  // index 0: rising-edge divider, index 1: falling-edge divider
  assign edge_hit[0] = en &  s_cur & ~s_prev;
  assign edge_hit[1] = en & ~s_cur &  s_prev;

  for (genvar g = 0; g < 2; g++) begin : g_div
    logic [SW:0] sum;
    assign sum = {1'b0, div_q[g]} + (SW+1)'(2);
    always_ff @(posedge clk) begin
      if (rst)
        div_q[g] <= SW'(g);
      else if (edge_hit[g])
        div_q[g] <= (sum >= (SW+1)'(NSLOT)) ? SW'(sum - (SW+1)'(NSLOT)) : sum[SW-1:0];
    end
  end

  assign adv  = |edge_hit;
  assign slot = edge_hit[0] ? div_q[0] : div_q[1];

  a_r5_div_range: assert property (@(posedge clk) disable iff (rst)
    (div_q[0] < SW'(NSLOT)) && (div_q[1] < SW'(NSLOT)));
  a_r5_one_edge: assert property (@(posedge clk) disable iff (rst)
    !(edge_hit[0] && edge_hit[1]));
endmodule

// File: rtl/cg_phase_out.sv
module cg_phase_out #(
  parameter int NSLOT     = 7,
  parameter int SAMP_HIGH = 4,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [SW-1:0]    slot,
  output logic [NSLOT-1:0] phase_oh,
  output logic             samp_clk
);
  logic [NSLOT-1:0] dec;

  always_comb begin
    dec = '0;
    for (int i = 0; i < NSLOT; i++)
      if (slot == SW'(i)) dec[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_oh <= '0;
      samp_clk <= 1'b0;
    end else if (adv) begin
      phase_oh <= dec;
      samp_clk <= (slot < SW'(SAMP_HIGH));
    end
  end

  a_r9_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(phase_oh));
endmodule

// File: rtl/cg_irq_div.sv
module cg_irq_div #(
  parameter int IRQ_HALF = 200,
  localparam int CW = $clog2(IRQ_HALF + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic irq_clk
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      irq_clk <= 1'b0;
    end else if (adv) begin
      if (cnt == CW'(IRQ_HALF - 1)) begin
        cnt     <= '0;
        irq_clk <= ~irq_clk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst) cnt < CW'(IRQ_HALF));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(irq_clk));
endmodule

// File: rtl/corr_clkgen.sv
module corr_clkgen #(
  parameter int NSLOT     = 7,
  parameter int SAMP_HIGH = 4,
  parameter int IRQ_HALF  = 200,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_slave,
  input  logic             ref_tick,
  input  logic             slv_clk_in,
  output logic [NSLOT-1:0] phase_oh,
  output logic             samp_clk,
  output logic             slv_clk_out,
  output logic             irq_clk
);
  logic          m_adv, s_adv, adv;
  logic [SW-1:0] m_slot, s_slot, slot;

  cg_master_div #(.NSLOT(NSLOT)) u_mdiv (
    .clk(clk), .rst(rst), .en(~mode_slave), .tick(ref_tick),
    .adv(m_adv), .slot(m_slot), .half_clk(slv_clk_out)
  );

  cg_slave_div #(.NSLOT(NSLOT)) u_sdiv (
    .clk(clk), .rst(rst), .en(mode_slave), .lvl_in(slv_clk_in),
    .adv(s_adv), .slot(s_slot)
  );

  assign adv  = mode_slave ? s_adv  : m_adv;
  assign slot = mode_slave ? s_slot : m_slot;

  cg_phase_out #(.NSLOT(NSLOT), .SAMP_HIGH(SAMP_HIGH)) u_out (
    .clk(clk), .rst(rst), .adv(adv), .slot(slot),
    .phase_oh(phase_oh), .samp_clk(samp_clk)
  );

  cg_irq_div #(.IRQ_HALF(IRQ_HALF)) u_irq (
    .clk(clk), .rst(rst), .adv(adv), .irq_clk(irq_clk)
  );

  a_r2_one_active: assert property (@(posedge clk) disable iff (rst)
    adv |=> $countones(phase_oh) == 1);
  a_r5_consecutive: assert property (@(posedge clk) disable iff (rst)
    (adv && (|phase_oh)) |=> phase_oh == {$past(phase_oh[NSLOT-2:0]), $past(phase_oh[NSLOT-1])});
  a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
    (!mode_slave && ref_tick) |=> slv_clk_out != $past(slv_clk_out));
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    mode_slave |=> !slv_clk_out);
  a_r4_samp: assert property (@(posedge clk) disable iff (rst)
    (|phase_oh) |-> samp_clk == (|phase_oh[SAMP_HIGH-1:0]));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase_oh));
endmodule

// File: tb/corr_clkgen_test.sv
module corr_clkgen_test;
  localparam int NS = 7;
  localparam int HALF = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_slave = 1'b0;
  logic ref_tick = 1'b0;
  logic slv_clk_in = 1'b0;
  logic [NS-1:0] phase_oh;
  logic samp_clk, slv_clk_out, irq_clk;
  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  corr_clkgen uut (
    .clk(clk), .rst(rst), .mode_slave(mode_slave), .ref_tick(ref_tick),
    .slv_clk_in(slv_clk_in), .phase_oh(phase_oh), .samp_clk(samp_clk),
    .slv_clk_out(slv_clk_out), .irq_clk(irq_clk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic slave);
    @(negedge clk);
    rst = 1'b1; mode_slave = slave; ref_tick = 1'b0; slv_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic mtick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic stoggle();
    slv_clk_in = ~slv_clk_in;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    chk("R1 phase", 32'(phase_oh), 0);
    chk("R1 samp", 32'(samp_clk), 0);
    chk("R1 slvout", 32'(slv_clk_out), 0);
    chk("R1 irq", 32'(irq_clk), 0);

    // R2/R3/R4/R7 master sequence with varied gaps
    for (int k = 0; k < 3 * NS; k++) begin
      mtick();
      chk("R2 phase", 32'(phase_oh), 32'(1 << (k % NS)));
      chk("R3 slvout", 32'(slv_clk_out), 32'((k + 1) % 2));
      chk("R4 samp", 32'(samp_clk), 32'((k % NS) < 4));
      // R7: toggle slave input, outputs must hold
      slv_clk_in = ~slv_clk_in;
      repeat (1 + (k % 3)) @(negedge clk);
      chk("R7 hold", 32'(phase_oh), 32'(1 << (k % NS)));
    end

    // R5/R6 slave sequence
    do_reset(1'b1);
    chk("R9 none before advance", 32'(phase_oh), 0);
    for (int k = 0; k < 3 * NS; k++) begin
      stoggle();
      chk("R5 phase", 32'(phase_oh), 32'(1 << (k % NS)));
      chk("R4 samp slave", 32'(samp_clk), 32'((k % NS) < 4));
      chk("R6 slvout", 32'(slv_clk_out), 0);
      // R6: master strobe ignored
      mtick();
      @(negedge clk);
      chk("R6 tick ignored", 32'(phase_oh), 32'(1 << (k % NS)));
      repeat (k % 2) @(negedge clk);
    end

    // R8 interrupt clock
    do_reset(1'b0);
    for (int n = 1; n <= 2 * HALF + 10; n++) begin
      mtick();
      if (n == HALF - 1 || n == HALF || n == 2 * HALF - 1 || n == 2 * HALF || n == 2 * HALF + 10)
        chk("R8 irq", 32'(irq_clk), 32'((n / HALF) % 2));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule